// File: doc/BRIEF.md
# Fan Manager with Speed Measurement

This block looks after the cooling of a carrier board. It drives three speed-controlled fans with pulse-width modulation and switches six further fans on and off. Each of the six sits on a plug-in module slot, and each runs only when that slot holds a module. It also counts the tachometer pulses of the three speed-controlled fans. A byte-wide register port sets the enables and duty values and reads back the measured speeds. A serial slave in front of this port would normally drive it.

A summary flag tells the rest of the board whether cooling is complete. Complete means every speed-controlled fan is enabled and every fan of an occupied slot is enabled. Duty values are given in percent. Speeds are reported as pulses per second, and the bench tachometer produces one pulse per revolution.

Top module: `fan_manager`

## Requirements
- R1: After reset the enable register reads 0xFF and every duty register holds 30. The PWM outputs are therefore high for 30 of every 100 steps.
- R2: A write to address 0 replaces the enable byte, and a read of address 0 returns it.
- R3: `main_en_o[i]` equals enable bit i, for i in 0..2.
- R4: A write to address i+1 sets the duty of fan i. Its PWM output is high for exactly that many steps of each 100-step period, and each step lasts STEP_CYCLES clocks.
- R5: A duty above 100 behaves as 100, with the output always high. A duty of 0 keeps the output always low.
- R6: While a fan's enable bit is 0, its PWM output stays low.
- R7: Module fan k is enabled when enable bit 3 + (k mod 5) is 1 and its slot-present input (active low) is 0. The present input passes through a two-flop synchronizer first. Fans 0 and 5 share bit 3.
- R8: `all_on_o` is 1 when bits 0..2 are all 1 and every present slot's group bit is 1. Otherwise it is 0.
- R9: The read registers at addresses 1..3 return the number of tachometer rising edges of fan 1..3 counted in the last complete window of WINDOW_CYCLES clocks. They change only at the end of a window.
- R10: The edge count saturates at 255 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from address |
| mod_present_ni | input | 6 | Slot occupied, active low |
| tach_i | input | 3 | Tachometer sense lines |
| pwm_o | output | 3 | PWM drive of fans 1..3 |
| main_en_o | output | 3 | Enables of fans 1..3 |
| mod_en_o | output | 6 | Enables of the module fans |
| all_on_o | output | 1 | Every relevant fan enabled |

## Verification
A wrong duty register, phase counter or clamp changes the number of high cycles within one 100-step period, so the count over each period exposes it. A wrong group mapping or synchronizer depth appears on `mod_en_o` and `all_on_o` within three clocks of a slot change. A wrong edge counter shows up in the speed registers at the next window boundary, one window after the tachometer pattern settles.

// File: rtl/fanmgr_pkg.sv
package fanmgr_pkg;
   localparam int PCT_STEPS = 100;
   localparam int PHASE_W   = $clog2(PCT_STEPS);

   function automatic int group_of(input int fan, input int num_groups);
      return fan % num_groups;
   endfunction
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
   parameter int               WIDTH     = 1,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fm_sync needs at least two stages");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fm_pwm.sv
module fm_pwm
   import fanmgr_pkg::*;
#(
   parameter int DUTY_W = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic [DUTY_W-1:0]  duty_i,
   input  logic [PHASE_W-1:0] phase_i,
   output logic               pwm_o
);
   if (DUTY_W < PHASE_W + 1) begin : g_bad_width
      $error("fm_pwm duty width too small for a percent value");
   end

   localparam logic [DUTY_W-1:0] FULL = DUTY_W'(PCT_STEPS);

   logic [DUTY_W-1:0] duty_eff;
   assign duty_eff = (duty_i > FULL) ? FULL : duty_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pwm_o <= 1'b0;
      else         pwm_o <= en_i && (DUTY_W'(phase_i) < duty_eff);
   end
endmodule

// File: rtl/fm_tach.sv
module fm_tach #(
   parameter int STAGES = 2,
   parameter int CNT_W  = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tach_i,
   input  logic             win_end_i,
   output logic [CNT_W-1:0] rps_o
);
   logic             tach_s;
   logic             prev_q;
   logic             rise;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_next;

   fm_sync #(.WIDTH(1), .STAGES(STAGES), .RESET_VAL(1'b0)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (tach_i),
      .q_o   (tach_s)
   );

   assign rise     = tach_s & ~prev_q;
   assign cnt_next = (rise && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
         rps_o  <= '0;
      end else begin
         prev_q <= tach_s;
         if (win_end_i) begin
            rps_o <= cnt_next;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_next;
         end
      end
   end
endmodule

// File: rtl/fan_manager.sv
module fan_manager
   import fanmgr_pkg::*;
#(
   parameter int NUM_MAIN      = 3,
   parameter int NUM_MOD       = 6,
   parameter int DATA_W        = 8,
   parameter int DUTY_RESET    = 30,
   parameter int STEP_CYCLES   = 80,
   parameter int WINDOW_CYCLES = 200_000_000,
   parameter int SYNC_STAGES   = 2,
   localparam int ADDR_W       = $clog2(NUM_MAIN + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic               reg_wr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   input  logic [NUM_MOD-1:0] mod_present_ni,
   input  logic [NUM_MAIN-1:0] tach_i,
   output logic [NUM_MAIN-1:0] pwm_o,
   output logic [NUM_MAIN-1:0] main_en_o,
   output logic [NUM_MOD-1:0] mod_en_o,
   output logic               all_on_o
);
   localparam int NUM_GROUPS = DATA_W - NUM_MAIN;
   localparam int WIN_W      = $clog2(WINDOW_CYCLES);

   if (NUM_GROUPS < 1)                 begin : g_bad_groups $error("no enable bits left for module fans"); end
   if (WINDOW_CYCLES < 2)              begin : g_bad_window $error("window must be at least two cycles"); end
   if (STEP_CYCLES < 1)                begin : g_bad_step   $error("step length must be positive"); end
   if (DUTY_RESET > PCT_STEPS)         begin : g_bad_duty   $error("reset duty above 100 percent"); end

   logic [DATA_W-1:0]                 en_q;
   logic [NUM_MAIN-1:0][DATA_W-1:0]   duty_q;
   logic [NUM_MAIN-1:0][DATA_W-1:0]   rps;
   logic [NUM_MOD-1:0]                pres_n_s;
   logic [NUM_MOD-1:0]                slot_ok;
   logic [PHASE_W-1:0]                phase_q;
   logic                              step_tick;
   logic [WIN_W-1:0]                  win_q;
   logic                              win_end;

   // register writes
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= '1;
         duty_q <= {NUM_MAIN{DATA_W'(DUTY_RESET)}};
      end else if (reg_wr_i) begin
         if (reg_addr_i == '0) en_q <= reg_wdata_i;
         for (int i = 0; i < NUM_MAIN; i++) begin
            if (reg_addr_i == ADDR_W'(i + 1)) duty_q[i] <= reg_wdata_i;
         end
      end
   end

   // register reads
   always_comb begin
      reg_rdata_o = en_q;
      for (int i = 0; i < NUM_MAIN; i++) begin
         if (reg_addr_i == ADDR_W'(i + 1)) reg_rdata_o = rps[i];
      end
   end

   // PWM step timebase
   if (STEP_CYCLES == 1) begin : g_step_direct
      assign step_tick = 1'b1;
   end else begin : g_step_div
      localparam int PRE_W = $clog2(STEP_CYCLES);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                pre_q <= '0;
         else if (pre_q == PRE_W'(STEP_CYCLES - 1))  pre_q <= '0;
         else                                        pre_q <= pre_q + 1'b1;
      end
      assign step_tick = (pre_q == PRE_W'(STEP_CYCLES - 1));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        phase_q <= '0;
      else if (step_tick) phase_q <= (phase_q == PHASE_W'(PCT_STEPS - 1)) ? '0 : phase_q + 1'b1;
   end

   // measurement window
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      win_q <= '0;
      else if (win_end) win_q <= '0;
      else              win_q <= win_q + 1'b1;
   end
   assign win_end = (win_q == WIN_W'(WINDOW_CYCLES - 1));

   // speed-controlled fans
   for (genvar i = 0; i < NUM_MAIN; i++) begin : g_main
      fm_pwm #(.DUTY_W(DATA_W)) i_pwm (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .en_i   (en_q[i]),
         .duty_i (duty_q[i]),
         .phase_i(phase_q),
         .pwm_o  (pwm_o[i])
      );
      fm_tach #(.STAGES(SYNC_STAGES), .CNT_W(DATA_W)) i_tach (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .tach_i   (tach_i[i]),
         .win_end_i(win_end),
         .rps_o    (rps[i])
      );
   end
   assign main_en_o = en_q[NUM_MAIN-1:0];

   // module fans
   fm_sync #(.WIDTH(NUM_MOD), .STAGES(SYNC_STAGES), .RESET_VAL({NUM_MOD{1'b1}})) i_pres_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (mod_present_ni),
      .q_o   (pres_n_s)
   );

   for (genvar k = 0; k < NUM_MOD; k++) begin : g_mod
      localparam int BIT = NUM_MAIN + group_of(k, NUM_GROUPS);
      assign mod_en_o[k] = en_q[BIT] & ~pres_n_s[k];
      assign slot_ok[k]  = en_q[BIT] |  pres_n_s[k];
   end

   assign all_on_o = (&en_q[NUM_MAIN-1:0]) & (&slot_ok);
endmodule

// File: rtl/fm_checker.sv
module fm_checker
   import fanmgr_pkg::*;
#(
   parameter int NUM_MAIN    = 3,
   parameter int NUM_MOD     = 6,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 2
) (
   input logic                       clk_i,
   input logic                       rst_ni,
   input logic [ADDR_W-1:0]          reg_addr_i,
   input logic                       reg_wr_i,
   input logic [DATA_W-1:0]          reg_wdata_i,
   input logic [NUM_MOD-1:0]         mod_present_ni,
   input logic [NUM_MAIN-1:0][DATA_W-1:0] duty_q,
   input logic [NUM_MAIN-1:0][DATA_W-1:0] rps,
   input logic                       win_end,
   input logic [NUM_MAIN-1:0]        pwm_o,
   input logic [NUM_MAIN-1:0]        main_en_o,
   input logic [NUM_MOD-1:0]         mod_en_o,
   input logic                       all_on_o
);
   AST_ENABLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_addr_i == '0) |=> main_en_o == $past(reg_wdata_i[NUM_MAIN-1:0])); // R2

   AST_SUMMARY_NEEDS_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      all_on_o |-> (&main_en_o)); // R8

   AST_SPEED_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !win_end |=> $stable(rps)); // R9

   for (genvar i = 0; i < NUM_MAIN; i++) begin : g_main_chk
      AST_PWM_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !main_en_o[i] |=> !pwm_o[i]); // R6
      AST_PWM_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (main_en_o[i] && duty_q[i] >= DATA_W'(PCT_STEPS)) |=> pwm_o[i]); // R5
      AST_PWM_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (duty_q[i] == '0) |=> !pwm_o[i]); // R5
   end

   for (genvar k = 0; k < NUM_MOD; k++) begin : g_mod_chk
      AST_MODFAN_NEEDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         mod_en_o[k] |-> !$past(mod_present_ni[k], SYNC_STAGES)); // R7
   end
endmodule

bind fan_manager fm_checker #(
   .NUM_MAIN   (NUM_MAIN),
   .NUM_MOD    (NUM_MOD),
   .DATA_W     (DATA_W),
   .SYNC_STAGES(SYNC_STAGES),
   .ADDR_W     (ADDR_W)
) i_fm_checker (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .reg_addr_i    (reg_addr_i),
   .reg_wr_i      (reg_wr_i),
   .reg_wdata_i   (reg_wdata_i),
   .mod_present_ni(mod_present_ni),
   .duty_q        (duty_q),
   .rps           (rps),
   .win_end       (win_end),
   .pwm_o         (pwm_o),
   .main_en_o     (main_en_o),
   .mod_en_o      (mod_en_o),
   .all_on_o      (all_on_o)
);

// File: tb/test_fan_manager.sv
module test_fan_manager;
   localparam int WIN = 600;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [5:0] pres_n = '1;
   logic [2:0] tach = '0;
   logic [2:0] pwm;
   logic [2:0] main_en;
   logic [5:0] mod_en;
   logic       all_on;

   int errors = 0;
   int checks = 0;
   int per[3] = '{0, 0, 0};
   int tc[3]  = '{0, 0, 0};

   always #2.5 clk = ~clk;

   fan_manager #(.STEP_CYCLES(1), .WINDOW_CYCLES(WIN)) i_fan_manager (
      .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mod_present_ni(pres_n),
      .tach_i(tach), .pwm_o(pwm), .main_en_o(main_en), .mod_en_o(mod_en),
      .all_on_o(all_on));

   // tachometer generators, period in clocks, 0 means stopped
   always @(negedge clk) begin
      for (int i = 0; i < 3; i++) begin
         if (per[i] == 0) begin
            tach[i] = 1'b0;
         end else begin
            tc[i] = (tc[i] + 1) % per[i];
            tach[i] = (tc[i] < per[i] / 2) ? 1'b1 : 1'b0;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output int v);
      @(negedge clk); addr = a; #1; v = rdata;
   endtask

   task automatic count_pwm(output int c0, output int c1, output int c2);
      c0 = 0; c1 = 0; c2 = 0;
      repeat (3) @(negedge clk);
      repeat (100) begin
         @(negedge clk);
         c0 += pwm[0]; c1 += pwm[1]; c2 += pwm[2];
      end
   endtask

   function automatic int clampd(input int d);
      return (d > 100) ? 100 : d;
   endfunction

   function automatic int sat(input int p);
      if (p == 0) return 0;
      return (WIN / p > 255) ? 255 : WIN / p;
   endfunction

   task automatic tach_case(input int p0, input int p1, input int p2);
      int v;
      per[0] = p0; per[1] = p1; per[2] = p2;
      repeat (2 * WIN + 10) @(negedge clk);
      rreg(2'd1, v); chk("R9 speed fan1", v, sat(p0));
      rreg(2'd2, v); chk("R9 speed fan2", v, sat(p1));
      rreg(2'd3, v); chk("R10 speed fan3", v, sat(p2));
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int c0, c1, c2, v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rreg(2'd0, v);       chk("R1 enable reset", v, 8'hFF);
      chk("R3 main enables at reset", main_en, 3'b111);
      chk("R7 no slot present at reset", mod_en, 0);
      chk("R8 summary at reset", all_on, 1);
      rreg(2'd1, v);       chk("R9 speed zero after reset", v, 0);
      count_pwm(c0, c1, c2);
      chk("R1 fan1 reset duty", c0, 30);
      chk("R1 fan2 reset duty", c1, 30);
      chk("R1 fan3 reset duty", c2, 30);

      // R4 / R5 duty sweep 0..120 on all fans
      for (int d = 0; d <= 120; d++) begin
         wreg(2'd1, 8'(d));
         wreg(2'd2, 8'(120 - d));
         wreg(2'd3, 8'((d * 7) % 128));
         count_pwm(c0, c1, c2);
         chk("R4 fan1 duty", c0, clampd(d));
         chk("R5 fan2 duty clamp", c1, clampd(120 - d));
         chk("R4 fan3 duty", c2, clampd((d * 7) % 128));
      end

      // R6 disabled fans stay low
      wreg(2'd1, 8'd50); wreg(2'd2, 8'd50); wreg(2'd3, 8'd100);
      wreg(2'd0, 8'b1111_1010);
      rreg(2'd0, v); chk("R2 enable readback", v, 8'hFA);
      chk("R3 main enables", main_en, 3'b010);
      count_pwm(c0, c1, c2);
      chk("R6 fan1 disabled", c0, 0);
      chk("R6 fan2 enabled", c1, 50);
      chk("R6 fan3 disabled", c2, 0);

      // R2 R3 R7 R8 sweep over enable byte and slot presence
      for (int e = 0; e < 256; e++) begin
         wreg(2'd0, 8'(e));
         chk("R3 main enables", main_en, e & 7);
         for (int p = 0; p < 64; p++) begin
            int exp_mod;
            int exp_all;
            pres_n = 6'(p);
            repeat (3) @(negedge clk);
            exp_mod = 0;
            exp_all = ((e & 7) == 7) ? 1 : 0;
            for (int k = 0; k < 6; k++) begin
               int b;
               b = (e >> (3 + k % 5)) & 1;
               if (((p >> k) & 1) == 0) begin
                  exp_mod |= b << k;
                  if (b == 0) exp_all = 0;
               end
            end
            chk("R7 module fan enables", mod_en, exp_mod);
            chk("R8 summary flag", all_on, exp_all);
         end
      end
      pres_n = '1;
      wreg(2'd0, 8'hFF);

      // R9 R10 tachometer windows
      tach_case(4, 6, 2);
      tach_case(10, 12, 3);
      tach_case(0, 5, 8);

      finish_run();
   end
endmodule